// File: doc/BRIEF.md
# Integrating Converter Phase Sequencer

This block is the digital controller of a dual-slope or quad-slope integrating analog-to-digital converter. It steers the integrator front end through three analog switches: one that routes the unknown voltage to the integrator, one that routes a reference of opposite polarity, and one that shorts the integrator input. It also measures the time these phases take. A conversion first integrates the unknown input for a fixed number of clocks. It then de-integrates against the reference and counts clocks until the comparator reports that the integrator output has returned through zero. That count is the digital value.

In quad-slope mode, a zero-correction cycle runs before the measurement. The input is shorted for the same fixed interval and then de-integrated against the reference. The count from that cycle is taken off the measured count, and the difference is clamped at zero. The fixed integrate length is a parameter, so an integrator can cover a whole mains period and reject hum. A run-down that never reaches zero is cut off at a parameterised limit and reported as an error. The host side is a start input, a busy output, a one-cycle done strobe and a parallel result.

Top module: `islope_seq`

## Requirements
- R1: While reset is asserted, and after it is released, busy, done and err are 0, result is 0 and all switch selects are off until a conversion is started.
- R2: A start seen while idle raises busy on the next clock. Busy stays high until the clock in which done pulses, and done comes with busy low. A start seen while busy has no effect on the running conversion and produces no extra result.
- R3: The switch select sw_sel is never more than one-hot: bit 0 connects the unknown input, bit 1 the reference, bit 2 the input short. It is all-off whenever busy is low.
- R4: Between any two different active switch selects, there is at least one clock with all selects off.
- R5: Every integrate phase (input or short selected) lasts exactly T_INT clocks.
- R6: In dual-slope mode, result equals the number of reference-phase clocks in which cmp_pos was sampled high before the first clock in which it was sampled low (cmp_pos = 1 means the integrator has not yet crossed zero).
- R7: In quad-slope mode, the shorted-input integrate and its reference de-integrate come first, and the measurement cycle follows. The result is the measurement count minus the offset count. A later dual-slope conversion subtracts nothing.
- R8: In quad-slope mode, when the offset count is greater than or equal to the measurement count, the result is 0.
- R9: If cmp_pos is still high after MAX_DEINT reference-phase clocks in either pass, the conversion ends with done, err = 1 and result = 0. A valid count is therefore at most MAX_DEINT-1.
- R10: Done is a single-clock pulse. Result and err keep their values from one done pulse until the next.
- R11: The mode input quad_en is sampled only with the accepted start. Changing it during a conversion does not alter that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a conversion (taken when idle) |
| quad_en | input | 1 | 1 selects quad-slope mode, 0 selects dual-slope |
| cmp_pos | input | 1 | Comparator: 1 while the integrator has not crossed zero |
| sw_sel | output | 3 | Switch selects: bit0 input, bit1 reference, bit2 short |
| busy | output | 1 | High for the whole conversion |
| done | output | 1 | One-clock strobe when result and err are updated |
| result | output | RES_W | Converted count |
| err | output | 1 | Run-down timeout of the last conversion |

## Verification
The scoreboard tests the limits of the count. A run-down that crosses at once must give 0. The last valid count, MAX_DEINT-1, must come through unchanged, and one more high clock must give a timeout; a design with an off-by-one in the limit compare either loses the top code or reports a valid value where it should report an error. In quad-slope mode, offsets equal to and larger than the measurement are applied. A design that does not clamp returns a wrapped large number. A timeout in the offset pass must end the conversion early. A dual-slope conversion that follows a quad one catches an offset that was never cleared, and a mode change or second start in the middle of a conversion catches a mode that was not latched, or a start accepted while busy. Monitors on the switch outputs catch overlapping selects, a missing all-off gap and an integrate interval that is one clock short or long.

// File: rtl/islope_pkg.sv
// Shared definitions for the integrating converter sequencer.
// Assumes: the switch select vector is indexed by the SW_* constants below.
package islope_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_UP   = 2'd2,
        PH_DN   = 2'd3
    } phase_e;

    localparam int SW_N     = 3;
    localparam int SW_IN    = 0;
    localparam int SW_REF   = 1;
    localparam int SW_SHORT = 2;
endpackage

// File: rtl/islope_cnt.sv
// Phase timer shared by the integrate and de-integrate phases.
// Assumes: clr has priority over en. The owner never lets it wrap.
module islope_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    // Count clocks in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/islope_fsm.sv
// Phase controller: idle, all-off gap, integrate (input or short), de-integrate.
// Assumes: cnt is cleared in every gap clock and counts while cnt_en is high.
// The quad pass flag is latched only when a start is accepted.
module islope_fsm
    import islope_pkg::*;
#(
    parameter int T_INT     = 16,
    parameter int MAX_DEINT = 100,
    parameter int CW        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            quad_en,
    input  logic            cmp_pos,
    input  logic [CW-1:0]   cnt,
    output logic            cnt_clr,
    output logic            cnt_en,
    output logic            launch,
    output logic            cap_off,
    output logic            cap_meas,
    output logic            tmo,
    output logic            busy,
    output logic [SW_N-1:0] sw_sel
);
    localparam logic [CW-1:0] UP_LAST = CW'(T_INT - 1);
    localparam logic [CW-1:0] DN_LAST = CW'(MAX_DEINT - 1);

    phase_e phase_q, phase_d;
    logic   off_pass_q, off_pass_d;
    logic   to_dn_q, to_dn_d;

    // Work out the next phase and the strobes of this clock.
    always_comb begin
        phase_d    = phase_q;
        off_pass_d = off_pass_q;
        to_dn_d    = to_dn_q;
        cnt_clr    = 1'b0;
        cnt_en     = 1'b0;
        launch     = 1'b0;
        cap_off    = 1'b0;
        cap_meas   = 1'b0;
        tmo        = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    launch     = 1'b1;
                    phase_d    = PH_GAP;
                    to_dn_d    = 1'b0;
                    off_pass_d = quad_en;
                end
            end
            PH_GAP: begin
                cnt_clr = 1'b1;
                phase_d = to_dn_q ? PH_DN : PH_UP;
            end
            PH_UP: begin
                cnt_en = 1'b1;
                if (cnt == UP_LAST) begin
                    phase_d = PH_GAP;
                    to_dn_d = 1'b1;
                end
            end
            PH_DN: begin
                if (!cmp_pos) begin
                    if (off_pass_q) begin
                        cap_off    = 1'b1;
                        off_pass_d = 1'b0;
                        to_dn_d    = 1'b0;
                        phase_d    = PH_GAP;
                    end else begin
                        cap_meas = 1'b1;
                        phase_d  = PH_IDLE;
                    end
                end else if (cnt == DN_LAST) begin
                    tmo        = 1'b1;
                    off_pass_d = 1'b0;
                    phase_d    = PH_IDLE;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Hold the phase and the pass bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            off_pass_q <= 1'b0;
            to_dn_q    <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            off_pass_q <= off_pass_d;
            to_dn_q    <= to_dn_d;
        end
    end

    // Decode the switch selects from the registered phase (all-off in idle and gap).
    always_comb begin
        sw_sel = '0;
        if (phase_q == PH_UP) begin
            if (off_pass_q) sw_sel[SW_SHORT] = 1'b1;
            else            sw_sel[SW_IN]    = 1'b1;
        end else if (phase_q == PH_DN) begin
            sw_sel[SW_REF] = 1'b1;
        end
    end

    assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/islope_res.sv
// Result unit: keeps the offset count, subtracts it with a clamp at zero,
// and registers result, err and the done strobe.
// Assumes: launch, cap_off, cap_meas and tmo are mutually exclusive.
module islope_res #(
    parameter int CW    = 8,
    parameter int RES_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt,
    input  logic             launch,
    input  logic             cap_off,
    input  logic             cap_meas,
    input  logic             tmo,
    output logic [RES_W-1:0] result,
    output logic             err,
    output logic             done
);
    logic [RES_W-1:0] off_q;
    logic [RES_W-1:0] meas;
    logic [RES_W-1:0] diff;

    assign meas = RES_W'(cnt);
    assign diff = (meas >= off_q) ? (meas - off_q) : '0;

    // Clear the offset on each start and capture it at the end of the offset pass.
    always_ff @(posedge clk) begin
        if (!rst_n)       off_q <= '0;
        else if (launch)  off_q <= '0;
        else if (cap_off) off_q <= meas;
    end

    // Register the outcome and pulse done once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            err    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= cap_meas | tmo;
            if (cap_meas) begin
                result <= diff;
                err    <= 1'b0;
            end else if (tmo) begin
                result <= '0;
                err    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/islope_seq.sv
// Top of the integrating converter sequencer.
// Assumes: cmp_pos is already synchronous to clk, and the analog front end
// follows sw_sel within one clock.
module islope_seq
    import islope_pkg::*;
#(
    parameter int T_INT     = 16,
    parameter int MAX_DEINT = 100,
    parameter int RES_W     = $clog2(MAX_DEINT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             quad_en,
    input  logic             cmp_pos,
    output logic [2:0]       sw_sel,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             err
);
    localparam int CMAX = (T_INT > MAX_DEINT) ? T_INT : MAX_DEINT;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] cnt;
    logic cnt_clr, cnt_en, launch, cap_off, cap_meas, tmo;

    islope_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
    );

    islope_fsm #(.T_INT(T_INT), .MAX_DEINT(MAX_DEINT), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .quad_en(quad_en),
        .cmp_pos(cmp_pos), .cnt(cnt), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
        .launch(launch), .cap_off(cap_off), .cap_meas(cap_meas), .tmo(tmo),
        .busy(busy), .sw_sel(sw_sel)
    );

    islope_res #(.CW(CW), .RES_W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .launch(launch),
        .cap_off(cap_off), .cap_meas(cap_meas), .tmo(tmo),
        .result(result), .err(err), .done(done)
    );
endmodule

// File: rtl/islope_seq_chk.sv
// Property checker for islope_seq, attached with bind.
// Assumes: only the ports of the top module are observed.
module islope_seq_chk #(
    parameter int T_INT     = 16,
    parameter int MAX_DEINT = 100,
    parameter int RES_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       sw_sel,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic             err
);
    localparam int LW = $clog2(T_INT + 2);

    logic          up_now;
    logic [LW-1:0] up_len;

    assign up_now = sw_sel[0] | sw_sel[2];

    // Length of the current integrate phase, used for the R5 window.
    always_ff @(posedge clk) begin
        if (!rst_n)      up_len <= '0;
        else if (up_now) up_len <= up_len + 1'b1;
        else             up_len <= '0;
    end

    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (!busy && !done && !err && result == '0)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
    AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_sel)); // R3
    AST_SW_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sw_sel == 3'b000); // R3
    AST_SW_GAP: assert property (@(posedge clk) disable iff (!rst_n) ($past(sw_sel) != 3'b000 && sw_sel != 3'b000) |-> sw_sel == $past(sw_sel)); // R4
    AST_UP_LEN: assert property (@(posedge clk) disable iff (!rst_n) (up_len != '0 && !up_now) |-> up_len == LW'(T_INT)); // R5
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) err |-> result == '0); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(result) && $stable(err))); // R10
endmodule

bind islope_seq islope_seq_chk #(.T_INT(T_INT), .MAX_DEINT(MAX_DEINT), .RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .sw_sel(sw_sel), .busy(busy),
    .done(done), .result(result), .err(err)
);

// File: tb/sim_islope_seq.sv
// Scoreboard bench for islope_seq. The driver queues the expected outcomes,
// and the monitor compares them at each done strobe. A behavioural comparator
// holds cmp_pos high for a chosen number of reference-phase clocks.
module sim_islope_seq;
    localparam int CLK_PERIOD = 10;
    localparam int T_INT      = 16;
    localparam int MAX_DEINT  = 100;
    localparam int RES_W      = $clog2(MAX_DEINT + 1);
    localparam logic [2:0] SEL_IN    = 3'b001;
    localparam logic [2:0] SEL_REF   = 3'b010;
    localparam logic [2:0] SEL_SHORT = 3'b100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             quad_en = 1'b0;
    logic             cmp_pos = 1'b1;
    logic [2:0]       sw_sel;
    logic             busy, done, err;
    logic [RES_W-1:0] result;

    int checks = 0;
    int failures = 0;

    int exp_res_q[$];
    int exp_err_q[$];
    int exp_sel_q[$];
    string tag_q[$];

    int tgt0 = 0, tgt1 = 0, pass_idx = 0, ref_k = 0, cur_t = 0;
    int up_run = 0;
    logic [2:0] prev_sw = 3'b000, first_sw = 3'b000;

    islope_seq #(.T_INT(T_INT), .MAX_DEINT(MAX_DEINT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .quad_en(quad_en),
        .cmp_pos(cmp_pos), .sw_sel(sw_sel), .busy(busy), .done(done),
        .result(result), .err(err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Comparator model: high for the target number of reference clocks per run-down.
    always @(negedge clk) begin
        if (sw_sel == SEL_REF) begin
            if (ref_k == 0) cur_t = (pass_idx == 0) ? tgt0 : tgt1;
            cmp_pos = (ref_k < cur_t);
            ref_k++;
        end else begin
            if (ref_k != 0) pass_idx++;
            ref_k = 0;
            cmp_pos = 1'b1;
        end
    end

    // Monitor: switch rules and scoreboard compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(sw_sel) > 1)
                chk(1'b0, "R3", "sw_sel not one-hot", int'(sw_sel), 0);
            if (prev_sw != 3'b000 && sw_sel != 3'b000 && sw_sel != prev_sw)
                chk(1'b0, "R4", "no all-off gap, sw_sel", int'(sw_sel), 0);
            if (sw_sel == SEL_IN || sw_sel == SEL_SHORT) begin
                up_run++;
            end else if (up_run != 0) begin
                chk(up_run == T_INT, "R5", "integrate length", up_run, T_INT);
                up_run = 0;
            end
            if (first_sw == 3'b000 && sw_sel != 3'b000) first_sw = sw_sel;
            if (done) begin
                if (exp_res_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected done, queue depth", 0, 1);
                end else begin
                    automatic int er = exp_res_q.pop_front();
                    automatic int ee = exp_err_q.pop_front();
                    automatic int es = exp_sel_q.pop_front();
                    automatic string tg = tag_q.pop_front();
                    chk(int'(result) == er, tg, "result", int'(result), er);
                    chk(int'(err) == ee, tg, "err", int'(err), ee);
                    chk(int'(first_sw) == es, "R7", "first integrate select", int'(first_sw), es);
                end
                first_sw = 3'b000;
            end
            prev_sw = sw_sel;
        end
    end

    // Driver: queue the expectation, run one conversion, check the handshake.
    task automatic convert(input bit quad, input int t0, input int t1,
                           input int er, input int ee, input string tg,
                           input bit disturb);
        exp_res_q.push_back(er);
        exp_err_q.push_back(ee);
        exp_sel_q.push_back(quad ? int'(SEL_SHORT) : int'(SEL_IN));
        tag_q.push_back(tg);
        pass_idx = 0;
        tgt0 = t0;
        tgt1 = t1;
        @(negedge clk);
        start = 1'b1;
        quad_en = quad;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            quad_en = ~quad;   // R11: mode change mid-conversion
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", int'(done), 0);
        repeat (4) @(negedge clk);
        chk(int'(result) == er, "R10", "result held", int'(result), er);
        chk(exp_res_q.size() == 0, "R2", "pending results", exp_res_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", int'({busy, done}), 0);
        chk(sw_sel == 3'b000, "R1", "sw_sel in reset", int'(sw_sel), 0);
        chk(result == '0 && err == 1'b0, "R1", "result/err in reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && sw_sel == 3'b000, "R1", "idle after reset", int'(busy), 0);

        convert(1'b0, 37, 0, 37, 0, "R6", 1'b0);
        convert(1'b0, 0, 0, 0, 0, "R6", 1'b0);
        convert(1'b0, MAX_DEINT - 1, 0, MAX_DEINT - 1, 0, "R6", 1'b0);
        convert(1'b0, MAX_DEINT, 0, 0, 1, "R9", 1'b0);
        convert(1'b1, 12, 57, 45, 0, "R7", 1'b0);
        convert(1'b1, 30, 10, 0, 0, "R8", 1'b0);
        convert(1'b1, 25, 25, 0, 0, "R8", 1'b0);
        convert(1'b1, 150, 20, 0, 1, "R9", 1'b0);
        convert(1'b1, 5, 40, 35, 0, "R11", 1'b1);
        convert(1'b0, 7, 0, 7, 0, "R7", 1'b0);
        convert(1'b0, 63, 0, 63, 0, "R6", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule